// File: doc/BRIEF.md
# Quad-Channel Serial-Loaded Double-Buffered Code Register Bank

This block is the digital front end of a four-channel converter. A host shifts 16-bit words in over a three-wire serial slave port made of a select, a serial clock and a data line. Each word carries a two-bit channel address followed by a 14-bit code. When select rises, the word is committed to the staging register of the addressed channel. A separate active-low load strobe copies all four staging registers into the output registers. The output registers drive four parallel 14-bit buses. While the strobe is held low, the outputs follow the staging registers.

A serial output delays the incoming stream by 17 shifted bits, so several devices can be daisy-chained. An active-low preset input forces every staging and output register to zero code or to half-scale, chosen by a mode pin. The system reset does the same at power-on. All pins are sampled by a single fast system clock through two-flop synchronizers. That clock must run at least four times faster than the serial clock.

Top module: `qdac_front`

## Requirements
- R1: While `rst_ni` is low, every staging and output register takes 0000h if `half_i` is 0, or 2000h if `half_i` is 1. The shift register and `sdo_o` clear to 0. The outputs keep this value until a later load changes them.
- R2: A bit is shifted in, most significant first, on each rising edge of `sck_i` seen while `cs_ni` is low. Edges of `sck_i` while `cs_ni` is high leave the shift register unchanged.
- R3: On a rising edge of `cs_ni`, only the last 16 bits shifted in are used. Bits [15:14] form the address and bits [13:0] form the code, and any earlier bits are dropped.
- R4: Address 00 writes channel A (`dac_o[13:0]`), 01 writes B (`dac_o[27:14]`), 10 writes C (`dac_o[41:28]`) and 11 writes D (`dac_o[55:42]`). No other staging register changes.
- R5: While `ld_ni` is high and no preset is active, `dac_o` holds its value. This holds through serial writes.
- R6: While `ld_ni` is low, each output register copies its staging register on every system clock. A single low pulse therefore updates all four channels together.
- R7: If a commit and a low strobe occur in the same cycle, the staging register is written first. The output shows the new code one system cycle later.
- R8: While `pre_ni` is low, all staging and output registers are forced to 0000h (`half_i`=0) or 2000h (`half_i`=1). The preset overrides both commits and the strobe, and it leaves the shift register unchanged.
- R9: `sdo_o` presents the bit that was shifted in 17 shifting `sck_i` rising edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all pins |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| cs_ni | input | 1 | Serial select, active low; its rising edge commits the word |
| sck_i | input | 1 | Serial clock; its rising edge shifts data in |
| sdi_i | input | 1 | Serial data in, most significant bit first |
| ld_ni | input | 1 | Level-sensitive load strobe, active low |
| pre_ni | input | 1 | Preset, active low |
| half_i | input | 1 | Preset value select: 0 gives zero code, 1 gives half-scale |
| sdo_o | output | 1 | Serial data out for daisy chaining |
| dac_o | output | 56 | Four output register codes, channel A in the lowest 14 bits |

## Verification
A commit edge and a low load strobe can fall in the same system cycle. In that cycle the staging register and the output register would both be written. The bench provokes this by holding `ld_ni` low across complete serial writes. It then checks that `dac_o` shows the new code once the commit has passed through the synchronizers. The preset is also held low across a commit and a strobe, to show that it wins both contests.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int unsigned CH_NUM  = 4;
  localparam int unsigned CODE_W  = 14;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned SYNC_W  = 6;

  // bit order of the synchronized pin bundle
  typedef struct packed {
    logic cs_n;
    logic sck;
    logic sdi;
    logic ld_n;
    logic pre_n;
    logic half;
  } pins_t;

  localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, sdi: 1'b0,
                                  ld_n: 1'b1, pre_n: 1'b1, half: 1'b0};
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int unsigned WIDTH = 6,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[g];
        sync_q <= RST_VAL[g];
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign q_o[g] = sync_q;
  end
endmodule

// File: rtl/qdac_shift.sv
module qdac_shift #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              sdi_i,
  output logic [WORD_W-1:0] word_o,
  output logic              sdo_o
);
  logic [WORD_W-1:0] sr_q;
  logic              tail_q;

  // tail_q is the extra stage that yields the WORD_W+1 delay
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      tail_q <= 1'b0;
    end else if (shift_i) begin
      tail_q <= sr_q[WORD_W-1];
      sr_q   <= {sr_q[WORD_W-2:0], sdi_i};
    end
  end

  assign word_o = sr_q;
  assign sdo_o  = tail_q;
endmodule

// File: rtl/qdac_bank.sv
module qdac_bank #(
  parameter int unsigned CH_NUM = 4,
  parameter int unsigned CODE_W = 14,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     por_half_i,
  input  logic                     preset_i,
  input  logic                     half_i,
  input  logic                     wr_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [CODE_W-1:0]        code_i,
  input  logic                     xfer_i,
  output logic [CH_NUM*CODE_W-1:0] stage_o,
  output logic [CH_NUM*CODE_W-1:0] out_o
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W-1);

  logic [CODE_W-1:0] por_val, run_val;
  logic [CH_NUM-1:0] sel;

  assign por_val = por_half_i ? MID : '0;
  assign run_val = half_i     ? MID : '0;

  for (genvar g = 0; g < CH_NUM; g++) begin : g_ch
    logic [CODE_W-1:0] stage_q, out_q;

    assign sel[g] = wr_i && (addr_i == ADDR_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       stage_q <= por_val;
      else if (preset_i) stage_q <= run_val;
      else if (sel[g])   stage_q <= code_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       out_q <= por_val;
      else if (preset_i) out_q <= run_val;
      else if (xfer_i)   out_q <= stage_q;
    end

    assign stage_o[g*CODE_W +: CODE_W] = stage_q;
    assign out_o[g*CODE_W +: CODE_W]   = out_q;
  end
endmodule

// File: rtl/qdac_front.sv
module qdac_front
  import qdac_pkg::*;
#(
  parameter int unsigned NUM_CH = CH_NUM,
  parameter int unsigned DATA_W = CODE_W,
  parameter int unsigned SEL_W  = ADDR_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cs_ni,
  input  logic                     sck_i,
  input  logic                     sdi_i,
  input  logic                     ld_ni,
  input  logic                     pre_ni,
  input  logic                     half_i,
  output logic                     sdo_o,
  output logic [NUM_CH*DATA_W-1:0] dac_o
);
  localparam int unsigned WORD_W = SEL_W + DATA_W;

  pins_t pins_raw, pins_s;
  logic  sck_q, cs_q;
  logic  sck_rise, commit, shift_en;
  logic  [WORD_W-1:0] sr_word;
  logic  [NUM_CH*DATA_W-1:0] in_flat;

  assign pins_raw = '{cs_n: cs_ni, sck: sck_i, sdi: sdi_i,
                      ld_n: ld_ni, pre_n: pre_ni, half: half_i};

  qdac_sync #(.WIDTH(SYNC_W), .RST_VAL(PINS_IDLE)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_raw),
    .q_o    (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= pins_s.sck;
      cs_q  <= pins_s.cs_n;
    end
  end

  assign sck_rise = pins_s.sck & ~sck_q;
  assign commit   = pins_s.cs_n & ~cs_q;
  assign shift_en = sck_rise & ~pins_s.cs_n;

  qdac_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift_en),
    .sdi_i   (pins_s.sdi),
    .word_o  (sr_word),
    .sdo_o   (sdo_o)
  );

  qdac_bank #(.CH_NUM(NUM_CH), .CODE_W(DATA_W), .ADDR_W(SEL_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .por_half_i (half_i),
    .preset_i   (~pins_s.pre_n),
    .half_i     (pins_s.half),
    .wr_i       (commit),
    .addr_i     (sr_word[WORD_W-1 -: SEL_W]),
    .code_i     (sr_word[DATA_W-1:0]),
    .xfer_i     (~pins_s.ld_n),
    .stage_o    (in_flat),
    .out_o      (dac_o)
  );
endmodule

// File: rtl/qdac_front_chk.sv
module qdac_front_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 14,
  parameter int unsigned SEL_W  = 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       cs_s,
  input logic                       sck_rise,
  input logic                       ld_s,
  input logic                       pre_s,
  input logic                       half_s,
  input logic                       commit,
  input logic [SEL_W+DATA_W-1:0]    sr_word,
  input logic                       sdo_o,
  input logic [NUM_CH*DATA_W-1:0]   in_flat,
  input logic [NUM_CH*DATA_W-1:0]   dac_o
);
  localparam int unsigned WORD_W = SEL_W + DATA_W;
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W-1);

  logic [NUM_CH*DATA_W-1:0] pre_vec;
  logic [DATA_W-1:0]        sel_in;

  assign pre_vec = {NUM_CH{half_s ? MID : {DATA_W{1'b0}}}};
  assign sel_in  = in_flat[sr_word[WORD_W-1 -: SEL_W]*DATA_W +: DATA_W];

  p_no_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sck_rise || cs_s) |=> $stable(sr_word));

  p_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && pre_s) |=> sel_in == $past(sr_word[DATA_W-1:0]));

  p_stage_only_on_commit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_s && !commit) |=> $stable(in_flat));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_s && pre_s) |=> dac_o == $past(dac_o));

  p_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_s && pre_s) |=> dac_o == $past(in_flat));

  p_preset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pre_s |=> (dac_o == $past(pre_vec)) && (in_flat == $past(pre_vec)));

  p_sdo_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_rise && !cs_s) |=> sdo_o == $past(sr_word[WORD_W-1]));
endmodule

bind qdac_front qdac_front_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_s     (pins_s.cs_n),
  .sck_rise (sck_rise),
  .ld_s     (pins_s.ld_n),
  .pre_s    (pins_s.pre_n),
  .half_s   (pins_s.half),
  .commit   (commit),
  .sr_word  (sr_word),
  .sdo_o    (sdo_o),
  .in_flat  (in_flat),
  .dac_o    (dac_o)
);

// File: tb/tb_qdac_front.sv
module tb_qdac_front;
  localparam int CLK_PERIOD = 10;
  localparam int HS  = 4;   // system cycles per serial clock phase
  localparam int SET = 8;   // settle cycles after a pin change

  typedef struct {
    string       tag;
    bit          is_sdo;
    logic [63:0] exp;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, ld_n = 1'b1, pre_n = 1'b1, half = 1'b0;
  logic sdo;
  logic [55:0] dac;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [13:0] in_m[4], out_m[4];
  logic [15:0] sr_m = '0;
  logic        sdo_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qdac_front dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .ld_ni(ld_n), .pre_ni(pre_n), .half_i(half), .sdo_o(sdo), .dac_o(dac)
  );

  // monitor: compare one queued expectation per falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [63:0] act;
      it  = q.pop_front();
      act = it.is_sdo ? {63'd0, sdo} : {8'd0, dac};
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic push(input string tag, input bit is_sdo, input logic [63:0] exp);
    item_t it;
    it.tag = tag; it.is_sdo = is_sdo; it.exp = exp;
    q.push_back(it);
    while (q.size() != 0) @(posedge clk);
    #2;
  endtask

  task automatic expect_dac(input string tag);
    push(tag, 1'b0, {8'd0, out_m[3], out_m[2], out_m[1], out_m[0]});
  endtask

  task automatic model_update();
    if (!pre_n) begin
      for (int i = 0; i < 4; i++) begin
        in_m[i]  = half ? 14'h2000 : 14'h0;
        out_m[i] = half ? 14'h2000 : 14'h0;
      end
    end else if (!ld_n) begin
      for (int i = 0; i < 4; i++) out_m[i] = in_m[i];
    end
  endtask

  task automatic send_bit(input logic b);
    sdi = b;
    wait_cyc(HS);
    sck = 1'b1;
    if (!cs_n) begin
      sdo_m = sr_m[15];
      sr_m  = {sr_m[14:0], b};
    end
    wait_cyc(HS);
    sck = 1'b0;
  endtask

  task automatic begin_x();
    cs_n = 1'b0;
    wait_cyc(HS);
  endtask

  task automatic end_x();
    wait_cyc(HS);
    cs_n = 1'b1;
    wait_cyc(SET);
    if (pre_n) in_m[sr_m[15:14]] = sr_m[13:0];
    model_update();
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic write(input logic [1:0] ch, input logic [13:0] code);
    begin_x();
    send_word({ch, code});
    end_x();
  endtask

  task automatic strobe();
    ld_n = 1'b0;
    wait_cyc(SET);
    model_update();
    ld_n = 1'b1;
    wait_cyc(SET);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired before the sequence ended");
      summary();
      $finish;
    end
  end

  initial begin
    logic [19:0] pat;
    for (int i = 0; i < 4; i++) begin in_m[i] = '0; out_m[i] = '0; end
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(SET);
    expect_dac("R1 power-on zero code");

    // R9: serial output delay of 17 shifting edges
    pat = 20'b1011_0000_0000_0110_0101;
    begin_x();
    for (int k = 19; k >= 0; k--) begin
      send_bit(pat[k]);
      wait_cyc(1);
      push("R9 sdo delay", 1'b1, {63'd0, sdo_m});
    end
    end_x();
    expect_dac("R5 hold after commit");

    // R4: one write per address, strobe high
    write(2'b00, 14'h0123);
    expect_dac("R5 hold after write A");
    write(2'b01, 14'h1a5c);
    write(2'b10, 14'h2b7e);
    write(2'b11, 14'h3fff);
    expect_dac("R5 hold after writes B C D");
    strobe();
    expect_dac("R4 R6 all four channels updated by one strobe");

    // R2: clocks with select high are ignored
    for (int i = 0; i < 16; i++) send_bit(i[0]);
    begin_x();
    for (int i = 0; i < 8; i++) send_bit(i[1]);
    end_x();
    strobe();
    expect_dac("R2 clocks with select high ignored");

    // R3: long transfer keeps final 16 bits
    begin_x();
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    send_word({2'b01, 14'h0456});
    end_x();
    strobe();
    expect_dac("R3 24-bit transfer keeps last 16");

    // R7: commits while strobe held low
    ld_n = 1'b0;
    wait_cyc(SET);
    model_update();
    write(2'b10, 14'h1111);
    expect_dac("R7 write with strobe low");
    write(2'b00, 14'h3ace);
    expect_dac("R7 second write with strobe low");
    ld_n = 1'b1;
    wait_cyc(SET);

    // R8: preset to half-scale, overriding commit and strobe
    half = 1'b1;
    pre_n = 1'b0;
    wait_cyc(SET);
    model_update();
    expect_dac("R8 preset half-scale");
    ld_n = 1'b0;
    write(2'b11, 14'h0777);
    expect_dac("R8 preset wins over commit and strobe");
    ld_n = 1'b1;
    wait_cyc(SET);
    pre_n = 1'b1;
    wait_cyc(SET);
    strobe();
    expect_dac("R8 staging registers preset too");
    begin_x();
    end_x();
    strobe();
    expect_dac("R8 shift register kept through preset");

    // R8: preset to zero
    half = 1'b0;
    pre_n = 1'b0;
    wait_cyc(SET);
    model_update();
    pre_n = 1'b1;
    wait_cyc(SET);
    expect_dac("R8 preset zero code");

    // R1: reset with mode pin high
    half = 1'b1;
    rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin in_m[i] = 14'h2000; out_m[i] = 14'h2000; end
    sr_m = '0;
    sdo_m = 1'b0;
    wait_cyc(SET);
    expect_dac("R1 power-on half-scale");
    push("R1 sdo cleared", 1'b1, 64'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule